// File: doc/BRIEF.md
# Directory Ping-Pong Traffic Detector

This block sits next to a coherence directory. It watches cache lines that keep moving back and forth between a cache level and the level below it. Each tracked line has a small saturating counter for every movement path. A round trip is one eviction from a level followed by a refill into that same level while the line's entry is still held. A line whose count reaches a programmable threshold is treated as the target of a cross-core timing attack, and the block then issues defensive commands on a valid/ready channel.

The operating mode is taken from a configuration pin while reset is asserted. In inclusive mode only path A (last-level cache to memory) is counted, and a tripped line gets a single refetch command. In non-inclusive mode path A (private L2 to last-level cache) and path B (private L2 to memory) each have their own counter. A trip on either one produces a refetch command followed by a pin command, and the entry becomes pinned: directory replacement may not pick it as a victim until an unpin or clear event arrives.

The command side is a three-state machine. `ST_IDLE` moves to `ST_REFETCH` when an accepted event trips a counter. `ST_REFETCH` moves to `ST_PIN` on acceptance in non-inclusive mode, or back to `ST_IDLE` on acceptance in inclusive mode. `ST_PIN` returns to `ST_IDLE` on acceptance. Events are refused while a command is pending.

Top module: `pp_traffic_guard`

## Requirements
- R1: After reset `cmd_valid` is 0 and `evt_ready` is 1.
- R2: A round trip on a path is counted only when a fill (`evt_kind` 0) on that path follows an eviction (`evt_kind` 1) on the same path of the same tracked address. Repeated fills alone, or repeated evictions alone, add at most one count.
- R3: In inclusive mode (`cfg_noninc` 0 at reset), the round trip that brings a line's path A count to THRESH (default 4) yields exactly one command with `cmd_op` 0 (refetch) carrying that address, and no command with `cmd_op` 1.
- R4: In inclusive mode, events on path B (`evt_path` 1) never produce a command.
- R5: In non-inclusive mode, reaching THRESH on either path yields a refetch command (`cmd_op` 0) followed directly by a pin command (`cmd_op` 1), both carrying the line's address, after which the machine returns to idle.
- R6: In non-inclusive mode the two paths are counted separately: THRESH-1 round trips on each path yield no command.
- R7: Counters are 4 bits wide and saturate at 15. A line keeps receiving round trips after tripping but gets no further command, even past 16 additional round trips.
- R8: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid`, `cmd_op` and `cmd_addr` hold their values.
- R9: `evt_ready` is 0 whenever a command is pending.
- R10: A pinned entry is never chosen as a replacement victim, so it keeps its count. An unpin event (`evt_kind` 2) makes it replaceable again.
- R11: When an entry is reallocated to another address its counters start from zero.
- R12: A clear event (`evt_kind` 3) drops the line's entry, so counting restarts from zero.
- R13: The mode is sampled only during reset. Changing `cfg_noninc` afterwards has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; mode sampled while low |
| cfg_noninc | input | 1 | 1 selects non-inclusive mode, 0 inclusive |
| evt_valid | input | 1 | Movement or control event present |
| evt_ready | output | 1 | Event accepted this cycle when high |
| evt_kind | input | 2 | 0 fill, 1 evict, 2 unpin, 3 clear |
| evt_path | input | 1 | 0 path A, 1 path B |
| evt_addr | input | ADDR_W | Line address |
| cmd_valid | output | 1 | Defensive command pending |
| cmd_ready | input | 1 | Command accepted when high with cmd_valid |
| cmd_op | output | 1 | 0 refetch line, 1 pin directory entry |
| cmd_addr | output | ADDR_W | Line address of the command |

## Verification
Interleaved evict/fill pairs are contrasted with runs of bare fills and bare evictions, so that genuine round trips are told apart from one-sided traffic. Path B traffic is sent in both modes, and split counts across both paths are sent in non-inclusive mode, to expose any shared or wrongly enabled counter. Long round-trip runs beyond sixteen separate saturation from a wrapping counter. Flooding the small table with fresh addresses, around pin, unpin and clear events, shows through the presence or absence of a later command whether an entry's count survived.

// File: rtl/pp_guard_pkg.sv
package pp_guard_pkg;

    typedef enum logic [1:0] {
        EV_FILL  = 2'd0,
        EV_EVICT = 2'd1,
        EV_UNPIN = 2'd2,
        EV_CLEAR = 2'd3
    } ev_kind_t;

    typedef enum logic {
        CMD_REFETCH = 1'b0,
        CMD_PIN     = 1'b1
    } cmd_op_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_REFETCH = 2'd1,
        ST_PIN     = 2'd2
    } cmd_state_t;

endpackage

// File: rtl/pp_victim_sel.sv
module pp_victim_sel #(
    parameter int ENTRIES = 4,
    parameter int IDX_W   = 2
) (
    input  logic [ENTRIES-1:0] vld_vec,
    input  logic [ENTRIES-1:0] pin_vec,
    input  logic [IDX_W-1:0]   rr_ptr,
    output logic [IDX_W-1:0]   victim_idx,
    output logic               victim_ok,
    output logic               victim_free
);

    // Free entries first (lowest index); otherwise round-robin over unpinned ones.
    always_comb begin
        victim_idx  = '0;
        victim_ok   = 1'b0;
        victim_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld_vec[i]) begin
                victim_idx  = IDX_W'(i);
                victim_free = 1'b1;
            end
        end
        if (victim_free) begin
            victim_ok = 1'b1;
        end else begin
            for (int k = ENTRIES - 1; k >= 0; k--) begin
                if (!pin_vec[(int'(rr_ptr) + k) % ENTRIES]) begin
                    victim_idx = IDX_W'((int'(rr_ptr) + k) % ENTRIES);
                    victim_ok  = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pp_dir_table.sv
module pp_dir_table
    import pp_guard_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int ENTRIES = 4,
    parameter int CNT_W   = 4,
    parameter int THRESH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              noninc,
    input  logic              evt_fire,
    input  logic [1:0]        evt_kind,
    input  logic              evt_path,
    input  logic [ADDR_W-1:0] evt_addr,
    output logic              trig,
    output logic [ADDR_W-1:0] trig_addr
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int NPATH = 2;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_PRE = CNT_W'(THRESH - 1);

    logic [ENTRIES-1:0] vld_q;
    logic [ENTRIES-1:0] pin_q;
    logic [ADDR_W-1:0]  tag_q  [ENTRIES];
    logic [NPATH-1:0]   away_q [ENTRIES];
    logic [CNT_W-1:0]   cnt_q  [ENTRIES][NPATH];
    logic [IDX_W-1:0]   rr_q;

    logic [ENTRIES-1:0] hit_vec;
    logic               hit;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   victim_idx;
    logic               victim_ok;
    logic               victim_free;
    ev_kind_t           kind;
    logic               path_on;
    logic               use_move;
    logic               do_alloc;
    logic               count_hit;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            assign hit_vec[g] = vld_q[g] && (tag_q[g] == evt_addr);
        end
    endgenerate

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    pp_victim_sel #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_victim (
        .vld_vec     (vld_q),
        .pin_vec     (pin_q),
        .rr_ptr      (rr_q),
        .victim_idx  (victim_idx),
        .victim_ok   (victim_ok),
        .victim_free (victim_free)
    );

    always_comb begin
        kind      = ev_kind_t'(evt_kind);
        path_on   = noninc || !evt_path;
        use_move  = evt_fire && path_on && (kind == EV_FILL || kind == EV_EVICT);
        do_alloc  = use_move && !hit && victim_ok;
        count_hit = use_move && hit && (kind == EV_FILL) && away_q[hit_idx][evt_path];
        trig      = count_hit && (cnt_q[hit_idx][evt_path] == CNT_PRE);
        trig_addr = evt_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            pin_q <= '0;
            rr_q  <= '0;
            for (int e = 0; e < ENTRIES; e++) begin
                tag_q[e]  <= '0;
                away_q[e] <= '0;
                for (int p = 0; p < NPATH; p++) begin
                    cnt_q[e][p] <= '0;
                end
            end
        end else begin
            if (do_alloc) begin
                vld_q[victim_idx]            <= 1'b1;
                pin_q[victim_idx]            <= 1'b0;
                tag_q[victim_idx]            <= evt_addr;
                away_q[victim_idx]           <= '0;
                away_q[victim_idx][evt_path] <= (kind == EV_EVICT);
                for (int p = 0; p < NPATH; p++) begin
                    cnt_q[victim_idx][p] <= '0;
                end
                if (!victim_free) begin
                    rr_q <= (int'(victim_idx) == ENTRIES - 1) ? '0 : victim_idx + 1'b1;
                end
            end
            if (use_move && hit) begin
                if (kind == EV_EVICT) begin
                    away_q[hit_idx][evt_path] <= 1'b1;
                end else begin
                    away_q[hit_idx][evt_path] <= 1'b0;
                    if (count_hit && cnt_q[hit_idx][evt_path] != CNT_MAX) begin
                        cnt_q[hit_idx][evt_path] <= cnt_q[hit_idx][evt_path] + 1'b1;
                    end
                end
            end
            if (trig && noninc) begin
                pin_q[hit_idx] <= 1'b1;
            end
            if (evt_fire && hit && kind == EV_UNPIN) begin
                pin_q[hit_idx] <= 1'b0;
            end
            if (evt_fire && hit && kind == EV_CLEAR) begin
                vld_q[hit_idx] <= 1'b0;
                pin_q[hit_idx] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pp_cmd_fsm.sv
module pp_cmd_fsm
    import pp_guard_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              noninc,
    input  logic              trig,
    input  logic [ADDR_W-1:0] trig_addr,
    input  logic              cmd_ready,
    output logic              cmd_valid,
    output logic              cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              busy
);

    cmd_state_t        state_q;
    cmd_state_t        state_d;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && trig) begin
                addr_q <= trig_addr;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (trig) state_d = ST_REFETCH;
            ST_REFETCH: if (cmd_ready) state_d = noninc ? ST_PIN : ST_IDLE;
            ST_PIN:     if (cmd_ready) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cmd_valid = 1'b0;
        cmd_op    = CMD_REFETCH;
        busy      = 1'b1;
        unique case (state_q)
            ST_IDLE:    busy = 1'b0;
            ST_REFETCH: cmd_valid = 1'b1;
            ST_PIN: begin
                cmd_valid = 1'b1;
                cmd_op    = CMD_PIN;
            end
            default:    busy = 1'b0;
        endcase
        cmd_addr = addr_q;
    end

endmodule

// File: rtl/pp_traffic_guard.sv
module pp_traffic_guard
    import pp_guard_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int ENTRIES = 4,
    parameter int CNT_W   = 4,
    parameter int THRESH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_noninc,
    input  logic              evt_valid,
    output logic              evt_ready,
    input  logic [1:0]        evt_kind,
    input  logic              evt_path,
    input  logic [ADDR_W-1:0] evt_addr,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_op,
    output logic [ADDR_W-1:0] cmd_addr
);

    logic              mode_q;
    logic              busy;
    logic              evt_fire;
    logic              trig;
    logic [ADDR_W-1:0] trig_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= cfg_noninc;
        end
    end

    assign evt_ready = !busy;
    assign evt_fire  = evt_valid && !busy;

    pp_dir_table #(
        .ADDR_W  (ADDR_W),
        .ENTRIES (ENTRIES),
        .CNT_W   (CNT_W),
        .THRESH  (THRESH)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .noninc    (mode_q),
        .evt_fire  (evt_fire),
        .evt_kind  (evt_kind),
        .evt_path  (evt_path),
        .evt_addr  (evt_addr),
        .trig      (trig),
        .trig_addr (trig_addr)
    );

    pp_cmd_fsm #(
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .noninc    (mode_q),
        .trig      (trig),
        .trig_addr (trig_addr),
        .cmd_ready (cmd_ready),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .busy      (busy)
    );

endmodule

// File: rtl/pp_traffic_guard_chk.sv
module pp_traffic_guard_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_q,
    input logic              evt_ready,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              cmd_op,
    input logic [ADDR_W-1:0] cmd_addr
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        $rose(rst_n) |-> (!cmd_valid && evt_ready)); // R1

    AST_INCL_NO_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> !(cmd_valid && cmd_op)); // R3

    AST_PIN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && cmd_valid && cmd_ready && !cmd_op)
        |=> (cmd_valid && cmd_op && $stable(cmd_addr))); // R5

    AST_PIN_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op) |=> !cmd_valid); // R5

    AST_HOLD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready)
        |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_addr))); // R8

    AST_NO_EVT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !evt_ready); // R9

endmodule

bind pp_traffic_guard pp_traffic_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_q    (mode_q),
    .evt_ready (evt_ready),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr)
);

// File: tb/pp_traffic_guard_test.sv
`timescale 1ns/1ps
module pp_traffic_guard_test;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_noninc = 1'b0;
    logic          evt_valid = 1'b0;
    logic          evt_ready;
    logic [1:0]    evt_kind = 2'd0;
    logic          evt_path = 1'b0;
    logic [AW-1:0] evt_addr = '0;
    logic          cmd_valid;
    logic          cmd_ready = 1'b1;
    logic          cmd_op;
    logic [AW-1:0] cmd_addr;

    int checks = 0;
    int errors = 0;
    int log_n = 0;
    int base = 0;
    logic          log_op   [64];
    logic [AW-1:0] log_addr [64];

    always #2.5 clk = ~clk;

    pp_traffic_guard uut (
        .clk(clk), .rst_n(rst_n), .cfg_noninc(cfg_noninc),
        .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_kind(evt_kind),
        .evt_path(evt_path), .evt_addr(evt_addr),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr)
    );

    always @(posedge clk) begin
        if (rst_n && cmd_valid && cmd_ready && log_n < 64) begin
            log_op[log_n]   <= cmd_op;
            log_addr[log_n] <= cmd_addr;
            log_n           <= log_n + 1;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(logic mode);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_noninc = mode;
        evt_valid = 1'b0;
        cmd_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        base = log_n;
    endtask

    task automatic ev(logic [1:0] kind, logic path, logic [AW-1:0] addr);
        @(negedge clk);
        while (!evt_ready) @(negedge clk);
        evt_valid = 1'b1;
        evt_kind  = kind;
        evt_path  = path;
        evt_addr  = addr;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic rt(logic [AW-1:0] addr, logic path, int n);
        for (int i = 0; i < n; i++) begin
            ev(2'd1, path, addr);
            ev(2'd0, path, addr);
        end
    endtask

    task automatic flood(logic [AW-1:0] start);
        for (int i = 0; i < 4; i++) ev(2'd0, 1'b0, start + AW'(i));
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic chk_entry(string req, int idx, int op, logic [AW-1:0] addr);
        chk(req, int'(log_op[base + idx]), op);
        chk(req, int'(log_addr[base + idx]), int'(addr));
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        chk("R1 cmd_valid", int'(cmd_valid), 0);
        chk("R1 evt_ready", int'(evt_ready), 1);
    endtask

    task automatic t_roundtrip_rule();
        do_reset(1'b0);
        for (int i = 0; i < 6; i++) ev(2'd0, 1'b0, 16'h0100);
        for (int i = 0; i < 6; i++) ev(2'd1, 1'b0, 16'h0100);
        settle();
        chk("R2 one-sided traffic", log_n - base, 0);
        ev(2'd0, 1'b0, 16'h0100);
        rt(16'h0100, 1'b0, 2);
        settle();
        chk("R2 count three", log_n - base, 0);
        rt(16'h0100, 1'b0, 1);
        settle();
        chk("R3 trip count", log_n - base, 1);
        chk_entry("R3 refetch", 0, 0, 16'h0100);
    endtask

    task automatic t_incl_path_b();
        do_reset(1'b0);
        rt(16'h0200, 1'b1, 6);
        settle();
        chk("R4 path B ignored", log_n - base, 0);
    endtask

    task automatic t_saturate();
        do_reset(1'b0);
        rt(16'h0300, 1'b0, 24);
        settle();
        chk("R7 single command", log_n - base, 1);
    endtask

    task automatic t_hold();
        do_reset(1'b0);
        cmd_ready = 1'b0;
        rt(16'h0400, 1'b0, 4);
        repeat (5) @(negedge clk);
        chk("R8 valid held", int'(cmd_valid), 1);
        chk("R8 addr held", int'(cmd_addr), 16'h0400);
        chk("R9 evt_ready low", int'(evt_ready), 0);
        cmd_ready = 1'b1;
        settle();
        chk("R8 one accepted", log_n - base, 1);
        chk("R9 ready again", int'(evt_ready), 1);
    endtask

    task automatic t_noninc_split();
        do_reset(1'b1);
        rt(16'h0500, 1'b0, 3);
        rt(16'h0500, 1'b1, 3);
        settle();
        chk("R6 split counts", log_n - base, 0);
        rt(16'h0500, 1'b1, 1);
        settle();
        chk("R5 two commands", log_n - base, 2);
        chk_entry("R5 refetch first", 0, 0, 16'h0500);
        chk_entry("R5 pin second", 1, 1, 16'h0500);
    endtask

    task automatic t_pin_unpin();
        do_reset(1'b1);
        rt(16'h0600, 1'b0, 4);
        settle();
        chk("R5 path A trip", log_n - base, 2);
        base = log_n;
        flood(16'h1000);
        rt(16'h0600, 1'b0, 4);
        settle();
        chk("R10 pinned kept", log_n - base, 0);
        ev(2'd2, 1'b0, 16'h0600);
        flood(16'h2000);
        rt(16'h0600, 1'b0, 4);
        settle();
        chk("R10 unpinned replaced", log_n - base, 2);
    endtask

    task automatic t_realloc();
        do_reset(1'b0);
        rt(16'h0700, 1'b0, 3);
        flood(16'h3000);
        rt(16'h0700, 1'b0, 1);
        settle();
        chk("R11 reset on realloc", log_n - base, 0);
        rt(16'h0700, 1'b0, 3);
        settle();
        chk("R11 fresh count trips", log_n - base, 1);
    endtask

    task automatic t_clear();
        do_reset(1'b0);
        rt(16'h0800, 1'b0, 3);
        ev(2'd3, 1'b0, 16'h0800);
        rt(16'h0800, 1'b0, 1);
        settle();
        chk("R12 cleared", log_n - base, 0);
        rt(16'h0800, 1'b0, 3);
        settle();
        chk("R12 restart trips", log_n - base, 1);
    endtask

    task automatic t_mode_latch();
        do_reset(1'b0);
        cfg_noninc = 1'b1;
        rt(16'h0900, 1'b1, 4);
        settle();
        chk("R13 path B still ignored", log_n - base, 0);
        rt(16'h0900, 1'b0, 4);
        settle();
        chk("R13 refetch only", log_n - base, 1);
        chk_entry("R13 op", 0, 0, 16'h0900);
    endtask

    bit done = 0;

    initial begin
        t_reset();
        t_roundtrip_rule();
        t_incl_path_b();
        t_saturate();
        t_hold();
        t_noninc_split();
        t_pin_unpin();
        t_realloc();
        t_clear();
        t_mode_latch();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule